// File: doc/BRIEF.md
# Live-Line Way Selection Filter

This block sits beside a set-associative cache. It keeps one counting membership filter for each cache way. It answers, for a lookup address, which ways could currently hold that line as a live line. Each filter entry is selected by the cache set index extended with a few low tag bits. The entry is a small saturating counter of the live lines that map onto it. The counter in a way goes up when the cache fills a line into that way. It goes down when the cache reports that a line in that way has decayed. The filter therefore tracks only live lines and drops dead ones without any search.

A lookup returns a presence vector with one bit per way. The cache enables only the flagged ways, so a hit is never missed. Several bits may be set together. When no bit is set, the miss-predict output tells the pipeline that it can skip the cache array and go straight to the next level. Lookups read the counters combinationally. An insert or decay event changes a counter at the next rising clock edge, and its effect is visible to lookups in the cycle after that edge.

Each counter behaves as a small state machine with three operations: HOLD, INC and DEC. The operation is chosen from the event inputs that reach the counter. INC moves the counter toward its ceiling and stays at the ceiling once it is reached. DEC moves the counter toward zero and stays at zero once it is reached. HOLD leaves the counter unchanged. The transitions are named in the requirements below.

Top module: `live_way_filter`

## Requirements
- R1: While reset is low, and at the first clock after it rises, every counter is zero. The presence vector is all zeros and miss_pred is 1.
- R2: An entry is selected by address bits [OFS_BITS +: SET_BITS+EXT_BITS]. These are the set index plus EXT_BITS low tag bits. Addresses that differ only above that field share an entry. Addresses that differ inside it do not share an entry.
- R3: An insert (ins_valid=1) at ins_addr into way ins_way performs INC on that way's entry. Presence bit ins_way is 1 for that address from the cycle after the clock edge.
- R4: A decay event (dcy_valid=1) performs DEC only on the entry of way dcy_way. The entries of other ways that share the same index are untouched.
- R5: A presence bit is 1 exactly when its counter is nonzero. An entry that has received two inserts stays present after one decay and clears after the second.
- R6: INC saturates at 2**CNT_W-1, which is 3 for a 2-bit count. Four inserts followed by three decays leave the entry absent.
- R7: DEC on a zero counter leaves it at zero. A later single insert followed by a single decay leaves the entry absent.
- R8: An insert and a decay that reach the same entry of the same way in one cycle give HOLD. An insert and a decay to different ways in one cycle both apply.
- R9: miss_pred is 1 exactly when the presence vector is all zeros.
- R10: Several presence bits may be 1 at once when the same address is live in several ways.
- R11: Lookups alone never change any counter. A sweep over other lookup addresses does not change the presence vector seen for an earlier address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | ADDR_W | Lookup address |
| ins_valid | input | 1 | Line fill event |
| ins_way | input | $clog2(WAYS) | Way receiving the fill |
| ins_addr | input | ADDR_W | Address of the filled line |
| dcy_valid | input | 1 | Line decay event from the cache |
| dcy_way | input | $clog2(WAYS) | Way of the decayed line |
| dcy_addr | input | ADDR_W | Address of the decayed line |
| present_vec | output | WAYS | Per-way possible-live flags for lk_addr |
| miss_pred | output | 1 | All ways absent: predicted miss |

## Verification
The bench builds the block with four ways, a 16-bit address, 5 offset bits, 4 set bits, 2 extension bits and 2-bit counters. The index field is then address bits [10:5]. With this setup, one 16-bit constant can target an alias above bit 10 and a distinct entry through bit 10. With only four ways, the bench can set several presence bits at once and still observe every way in the vector. The 2-bit count means saturation at 3 is reached after four inserts. The clamp at zero shows up within a few cycles.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2
    } cnt_op_e;
endpackage

// File: rtl/lwf_index.sv
module lwf_index #(
    parameter int ADDR_W   = 32,
    parameter int OFS_BITS = 5,
    parameter int IDX_BITS = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [IDX_BITS-1:0] idx
);
    assign idx = addr[OFS_BITS +: IDX_BITS];
endmodule

// File: rtl/lwf_counter.sv
module lwf_counter import lwf_pkg::*; #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_op_e          op;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (inc && !dec)      op = OP_INC;
        else if (dec && !inc) op = OP_DEC;
        else                  op = OP_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (op)
            OP_INC:  if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
            OP_DEC:  if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
            OP_HOLD: cnt_d = cnt_q;
            default: cnt_d = cnt_q;
        endcase
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/lwf_way.sv
module lwf_way #(
    parameter int IDX_BITS = 8,
    parameter int CNT_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc_en,
    input  logic [IDX_BITS-1:0] inc_idx,
    input  logic                dec_en,
    input  logic [IDX_BITS-1:0] dec_idx,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic                rd_live
);
    localparam int ENTRIES = 1 << IDX_BITS;

    logic [CNT_W-1:0] cnt_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        lwf_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_en && (inc_idx == IDX_BITS'(e))),
            .dec   (dec_en && (dec_idx == IDX_BITS'(e))),
            .cnt   (cnt_q[e])
        );
    end

    assign rd_live = (cnt_q[rd_idx] != '0);
endmodule

// File: rtl/live_way_filter.sv
module live_way_filter #(
    parameter int WAYS     = 4,
    parameter int ADDR_W   = 32,
    parameter int OFS_BITS = 5,
    parameter int SET_BITS = 6,
    parameter int EXT_BITS = 2,
    parameter int CNT_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        lk_addr,
    input  logic                     ins_valid,
    input  logic [$clog2(WAYS)-1:0]  ins_way,
    input  logic [ADDR_W-1:0]        ins_addr,
    input  logic                     dcy_valid,
    input  logic [$clog2(WAYS)-1:0]  dcy_way,
    input  logic [ADDR_W-1:0]        dcy_addr,
    output logic [WAYS-1:0]          present_vec,
    output logic                     miss_pred
);
    localparam int IDX_BITS = SET_BITS + EXT_BITS;
    localparam int WAY_W    = $clog2(WAYS);

    logic [IDX_BITS-1:0] lk_idx;
    logic [IDX_BITS-1:0] ins_idx;
    logic [IDX_BITS-1:0] dcy_idx;

    lwf_index #(.ADDR_W(ADDR_W), .OFS_BITS(OFS_BITS), .IDX_BITS(IDX_BITS))
        u_lk_idx  (.addr(lk_addr),  .idx(lk_idx));
    lwf_index #(.ADDR_W(ADDR_W), .OFS_BITS(OFS_BITS), .IDX_BITS(IDX_BITS))
        u_ins_idx (.addr(ins_addr), .idx(ins_idx));
    lwf_index #(.ADDR_W(ADDR_W), .OFS_BITS(OFS_BITS), .IDX_BITS(IDX_BITS))
        u_dcy_idx (.addr(dcy_addr), .idx(dcy_idx));

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        lwf_way #(.IDX_BITS(IDX_BITS), .CNT_W(CNT_W)) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_en  (ins_valid && (ins_way == WAY_W'(w))),
            .inc_idx (ins_idx),
            .dec_en  (dcy_valid && (dcy_way == WAY_W'(w))),
            .dec_idx (dcy_idx),
            .rd_idx  (lk_idx),
            .rd_live (present_vec[w])
        );
    end

    assign miss_pred = ~|present_vec;
endmodule

// File: rtl/lwf_checker.sv
module lwf_checker #(
    parameter int WAYS     = 4,
    parameter int ADDR_W   = 32,
    parameter int OFS_BITS = 5,
    parameter int SET_BITS = 6,
    parameter int EXT_BITS = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       lk_addr,
    input logic                    ins_valid,
    input logic [$clog2(WAYS)-1:0] ins_way,
    input logic [ADDR_W-1:0]       ins_addr,
    input logic                    dcy_valid,
    input logic [$clog2(WAYS)-1:0] dcy_way,
    input logic [ADDR_W-1:0]       dcy_addr,
    input logic [WAYS-1:0]         present_vec,
    input logic                    miss_pred
);
    localparam int IDX_BITS = SET_BITS + EXT_BITS;
    localparam int WAY_W    = $clog2(WAYS);

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !dcy_valid) |=> ($stable(lk_addr) -> $stable(present_vec))); // R11

    for (genvar w = 0; w < WAYS; w++) begin : g_chk
        AST_RISE_NEEDS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
            !(ins_valid && ins_way == WAY_W'(w))
            |=> ($stable(lk_addr) -> !$rose(present_vec[w]))); // R3

        AST_FALL_NEEDS_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
            !(dcy_valid && dcy_way == WAY_W'(w))
            |=> ($stable(lk_addr) -> !$fell(present_vec[w]))); // R4

        AST_INSERT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
            (ins_valid && ins_way == WAY_W'(w) && !(dcy_valid && dcy_way == WAY_W'(w)))
            |=> ((lk_addr[OFS_BITS +: IDX_BITS] == $past(ins_addr[OFS_BITS +: IDX_BITS]))
                 -> present_vec[w])); // R3
    end
endmodule

bind live_way_filter lwf_checker #(
    .WAYS(WAYS), .ADDR_W(ADDR_W), .OFS_BITS(OFS_BITS),
    .SET_BITS(SET_BITS), .EXT_BITS(EXT_BITS)
) u_lwf_checker (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
    .ins_valid(ins_valid), .ins_way(ins_way), .ins_addr(ins_addr),
    .dcy_valid(dcy_valid), .dcy_way(dcy_way), .dcy_addr(dcy_addr),
    .present_vec(present_vec), .miss_pred(miss_pred)
);

// File: tb/live_way_filter_test.sv
`timescale 1ns/1ps
module live_way_filter_test;
    localparam int WAYS = 4;
    localparam int AW   = 16;

    typedef struct packed {
        logic          iv;
        logic [1:0]    iw;
        logic [AW-1:0] ia;
        logic          dv;
        logic [1:0]    dw;
        logic [AW-1:0] da;
        logic [AW-1:0] la;
        logic [3:0]    expv;
        logic [7:0]    req;
    } vec_t;

    // index field = addr[10:5]
    localparam logic [AW-1:0] A  = 16'h0040;
    localparam logic [AW-1:0] AA = 16'h8040;  // alias above the field
    localparam logic [AW-1:0] AX = 16'h0440;  // differs in extension tag bit
    localparam logic [AW-1:0] B  = 16'h0060;
    localparam logic [AW-1:0] C  = 16'h07E0;
    localparam logic [AW-1:0] Z  = 16'h0000;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, A, 1'b0, 2'd0, Z, A,  4'b0001, 8'd3 },  // R3
        '{1'b1, 2'd2, A, 1'b0, 2'd0, Z, A,  4'b0101, 8'd10},  // R10
        '{1'b0, 2'd0, Z, 1'b0, 2'd0, Z, AA, 4'b0101, 8'd2 },  // R2 alias
        '{1'b0, 2'd0, Z, 1'b0, 2'd0, Z, AX, 4'b0000, 8'd2 },  // R2 distinct
        '{1'b1, 2'd0, A, 1'b0, 2'd0, Z, A,  4'b0101, 8'd3 },  // R3 count 2
        '{1'b0, 2'd0, Z, 1'b1, 2'd0, A, A,  4'b0101, 8'd5 },  // R5 still live
        '{1'b0, 2'd0, Z, 1'b1, 2'd2, A, A,  4'b0001, 8'd4 },  // R4 only way 2
        '{1'b0, 2'd0, Z, 1'b1, 2'd0, A, A,  4'b0000, 8'd5 },  // R5 last decays
        '{1'b0, 2'd0, Z, 1'b1, 2'd1, B, B,  4'b0000, 8'd7 },  // R7 decay on empty
        '{1'b1, 2'd1, B, 1'b0, 2'd0, Z, B,  4'b0010, 8'd7 },  // R7
        '{1'b0, 2'd0, Z, 1'b1, 2'd1, B, B,  4'b0000, 8'd7 },  // R7 clamp held
        '{1'b1, 2'd1, B, 1'b0, 2'd0, Z, B,  4'b0010, 8'd3 },  // R3
        '{1'b1, 2'd3, B, 1'b1, 2'd3, B, B,  4'b0010, 8'd8 },  // R8 same entry
        '{1'b1, 2'd3, B, 1'b1, 2'd1, B, B,  4'b1000, 8'd8 },  // R8 diff ways
        '{1'b0, 2'd0, Z, 1'b0, 2'd0, Z, B,  4'b1000, 8'd11},  // R11
        '{1'b0, 2'd0, Z, 1'b0, 2'd0, Z, A,  4'b0000, 8'd11}   // R11
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [AW-1:0]   lk_addr, ins_addr, dcy_addr;
    logic            ins_valid, dcy_valid;
    logic [1:0]      ins_way, dcy_way;
    logic [WAYS-1:0] present_vec;
    logic            miss_pred;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    live_way_filter #(
        .WAYS(WAYS), .ADDR_W(AW), .OFS_BITS(5), .SET_BITS(4), .EXT_BITS(2), .CNT_W(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr),
        .ins_valid(ins_valid), .ins_way(ins_way), .ins_addr(ins_addr),
        .dcy_valid(dcy_valid), .dcy_way(dcy_way), .dcy_addr(dcy_addr),
        .present_vec(present_vec), .miss_pred(miss_pred)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input logic [3:0] exp);
        chk(tag, present_vec, exp);
        chk({tag, " R9"}, {3'b0, miss_pred}, {3'b0, (exp == 4'b0)});
    endtask

    task automatic step(input logic iv, input logic [1:0] iw, input logic [AW-1:0] ia,
                        input logic dv, input logic [1:0] dw, input logic [AW-1:0] da,
                        input logic [AW-1:0] la);
        @(negedge clk);
        ins_valid = iv; ins_way = iw; ins_addr = ia;
        dcy_valid = dv; dcy_way = dw; dcy_addr = da;
        lk_addr   = la;
        @(negedge clk);
        ins_valid = 1'b0; dcy_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lk_addr = A; ins_addr = Z; dcy_addr = Z;
        ins_valid = 1'b0; dcy_valid = 1'b0; ins_way = '0; dcy_way = '0;
        repeat (3) @(negedge clk);
        chk_state("R1 in reset", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1 after reset", 4'b0000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].iv, VEC[i].iw, VEC[i].ia, VEC[i].dv, VEC[i].dw, VEC[i].da, VEC[i].la);
            chk_state($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].expv);
        end

        // R11: sweep other lookup addresses, then return to B
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            lk_addr = AW'(k * 32);
        end
        @(negedge clk);
        lk_addr = B;
        @(negedge clk);
        chk_state("R11 after sweep", 4'b1000);

        // R6: saturation at 3
        for (int k = 0; k < 4; k++) step(1'b1, 2'd2, C, 1'b0, 2'd0, Z, C);
        chk_state("R6 after four inserts", 4'b0100);
        for (int k = 0; k < 3; k++) step(1'b0, 2'd0, Z, 1'b1, 2'd2, C, C);
        chk_state("R6 after three decays", 4'b0000);

        // R1: reset mid-run clears populated entries
        @(negedge clk);
        rst_n = 1'b0;
        lk_addr = B;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1 mid-run reset", 4'b0000);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule